// File: doc/BRIEF.md
# Gate Latency Trim Sequencer

This block runs once DRAM training has finished. It reads the gate latency that training left in each byte lane's gate-timing register and derives two corrections from it. The smallest quarter-latency across the lanes, plus a fixed offset, becomes a common read delay. The sequencer writes that delay into a 4-bit field of each lane's first general-config register and leaves every other bit of those registers as it was.

The largest latency, halved, becomes a turnaround increment. It is added twice into a controller timing register: once shifted into the read-to-write field and once unshifted into the write-to-read field. The controller must not take these changes while running, so both additions are enclosed in a software-update window. The window opens by clearing a flag and closes by setting it again. The block then polls an acknowledge flag and only reports completion once the controller has applied the settings, or once a poll budget runs out.

The block drives a simple register-bus master with one transaction in flight at a time. A start pulse launches the sequence. Busy stays high for the whole run, and done pulses for one cycle at the end, together with an error flag.

Top module: `gate_latency_trim`

## Requirements
- R1: After reset, busy, done, err and bus_req are all low, and no bus request is made while the block is idle.
- R2: A start pulse while idle begins the sequence. The first transaction writes 0 to the rank-select register, ahead of every lane read.
- R3: The gate latency of lane i is bits 4:0 of the gate-timing register at GTR_BASE+i. All higher bits are ignored. The lanes are read in order 0 to 3.
- R4: The read delay is the minimum over lanes of (latency >> 2), plus RD_OFFSET (5), clamped to 15. For each lane in order, the register at GCR_BASE+i is read and then written back with bits 23:20 replaced by the delay and all other bits unchanged.
- R5: The increment is the maximum lane latency shifted right by 1. The timing register at TMG_ADDR is read and written back with (increment << 8) added. It is then read again and written back with the increment added, with 32-bit wraparound.
- R6: Before the first timing-register access, the software-control register at SWCTL_ADDR is read and written back with bit 0 cleared. After the second timing write it is read and written back with bit 0 set. Other bits are preserved both times.
- R7: After bit 0 is set, the status register at SWSTAT_ADDR is read repeatedly until bit 0 reads 1. Done then pulses for one cycle with err low.
- R8: If ACK_TIMEOUT consecutive status reads return bit 0 = 0, done pulses with err high and no further status read is made. err stays high until the next start.
- R9: A start pulse while busy has no effect: no extra transactions and no second done.
- R10: While bus_req is high and bus_ack is low, bus_req, bus_we, bus_addr and bus_wdata hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| busy | output | 1 | High from start until completion |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Acknowledge timed out on the last run |
| bus_req | output | 1 | Register transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Transaction complete, one cycle |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |

## Verification
The bench feeds gate-timing words whose upper bits are set. A design that used the whole register as the latency would then pick the wrong minimum and maximum. Lane values all zero and all 31 stress the end points: the zero case exposes an adder that is skipped when the increment is zero, and the all-31 case, with the timing register close to wraparound, exposes a carry that is lost or an addition that lands in the wrong field. General-config words with ones on both sides of the delay field reveal a read-modify-write that clobbers neighbouring bits. A status flag that stays low checks that the poll budget ends with err set after exactly the right number of reads. A stray start in mid-run would appear as a duplicate rank-select write.

// File: rtl/gate_latency_trim.sv
module gate_latency_trim #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int LANES       = 4,
  parameter int LAT_W       = 5,
  parameter int RD_OFFSET   = 5,
  parameter int DLY_LSB     = 20,
  parameter int ACK_TIMEOUT = 1024,
  parameter logic [ADDR_W-1:0] RANK_ADDR   = 8'h10,
  parameter logic [ADDR_W-1:0] GTR_BASE    = 8'h20,
  parameter logic [ADDR_W-1:0] GCR_BASE    = 8'h30,
  parameter logic [ADDR_W-1:0] TMG_ADDR    = 8'h40,
  parameter logic [ADDR_W-1:0] SWCTL_ADDR  = 8'h41,
  parameter logic [ADDR_W-1:0] SWSTAT_ADDR = 8'h42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int TO_W   = $clog2(ACK_TIMEOUT + 1);
  localparam int Q_W    = LAT_W - 2;
  localparam logic [DATA_W-1:0] DLY_MASK = DATA_W'(4'hF) << DLY_LSB;

  typedef enum logic [3:0] {
    S_IDLE, S_RANK, S_GTR, S_GCR_RD, S_GCR_WR,
    S_SWC_RD, S_SWC_WR, S_TMG_RD, S_TMG_WR, S_SWS_RD
  } state_t;

  state_t            state;
  logic [LANE_W-1:0] lane;
  logic              tmg_second, swc_second;
  logic [Q_W-1:0]    qmin;
  logic [LAT_W-1:0]  lmax;
  logic [DATA_W-1:0] rdq;
  logic [TO_W-1:0]   polls;

  logic [LAT_W-1:0] lat;
  logic [7:0]       dly_sum;
  logic [3:0]       dly;
  logic [LAT_W-1:0] inc;
  logic             last_lane;

  assign lat       = bus_rdata[LAT_W-1:0];
  assign dly_sum   = 8'(qmin) + 8'(RD_OFFSET);
  assign dly       = (dly_sum > 8'd15) ? 4'hF : dly_sum[3:0];
  assign inc       = lmax >> 1;
  assign last_lane = (lane == LANE_W'(LANES - 1));

  assign busy    = (state != S_IDLE);
  assign bus_req = busy;
  assign bus_we  = (state == S_RANK) || (state == S_GCR_WR) ||
                   (state == S_SWC_WR) || (state == S_TMG_WR);

  always_comb begin
    bus_addr  = RANK_ADDR;
    bus_wdata = '0;
    unique case (state)
      S_GTR:              bus_addr = GTR_BASE + ADDR_W'(lane);
      S_GCR_RD: begin
        bus_addr  = GCR_BASE + ADDR_W'(lane);
      end
      S_GCR_WR: begin
        bus_addr  = GCR_BASE + ADDR_W'(lane);
        bus_wdata = (rdq & ~DLY_MASK) | (DATA_W'(dly) << DLY_LSB);
      end
      S_SWC_RD:           bus_addr = SWCTL_ADDR;
      S_SWC_WR: begin
        bus_addr  = SWCTL_ADDR;
        bus_wdata = swc_second ? (rdq | DATA_W'(1)) : (rdq & ~DATA_W'(1));
      end
      S_TMG_RD:           bus_addr = TMG_ADDR;
      S_TMG_WR: begin
        bus_addr  = TMG_ADDR;
        bus_wdata = tmg_second ? rdq + DATA_W'(inc) : rdq + (DATA_W'(inc) << 8);
      end
      S_SWS_RD:           bus_addr = SWSTAT_ADDR;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; lane <= '0; tmg_second <= 1'b0; swc_second <= 1'b0;
      qmin <= '1; lmax <= '0; rdq <= '0; polls <= '0;
      done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (bus_ack && !bus_we) rdq <= bus_rdata;
      case (state)
        S_IDLE: if (start) begin
          state <= S_RANK; err <= 1'b0; lane <= '0; qmin <= '1; lmax <= '0;
          tmg_second <= 1'b0; swc_second <= 1'b0; polls <= '0;
        end
        S_RANK: if (bus_ack) state <= S_GTR;
        S_GTR: if (bus_ack) begin
          if (lat[LAT_W-1:2] < qmin) qmin <= lat[LAT_W-1:2];
          if (lat > lmax) lmax <= lat;
          lane  <= last_lane ? '0 : lane + 1'b1;
          state <= last_lane ? S_GCR_RD : S_GTR;
        end
        S_GCR_RD: if (bus_ack) state <= S_GCR_WR;
        S_GCR_WR: if (bus_ack) begin
          lane  <= last_lane ? '0 : lane + 1'b1;
          state <= last_lane ? S_SWC_RD : S_GCR_RD;
        end
        S_SWC_RD: if (bus_ack) state <= S_SWC_WR;
        S_SWC_WR: if (bus_ack) state <= swc_second ? S_SWS_RD : S_TMG_RD;
        S_TMG_RD: if (bus_ack) state <= S_TMG_WR;
        S_TMG_WR: if (bus_ack) begin
          if (tmg_second) begin
            swc_second <= 1'b1;
            state      <= S_SWC_RD;
          end else begin
            tmg_second <= 1'b1;
            state      <= S_TMG_RD;
          end
        end
        S_SWS_RD: if (bus_ack) begin
          if (bus_rdata[0]) begin
            done <= 1'b1; state <= S_IDLE;
          end else if (polls == TO_W'(ACK_TIMEOUT - 1)) begin
            done <= 1'b1; err <= 1'b1; state <= S_IDLE;
          end else begin
            polls <= polls + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);
  assert_rank_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_req && bus_we && bus_addr == RANK_ADDR && bus_wdata == '0));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));
endmodule

// File: tb/tb_gate_latency_trim.sv
module tb_gate_latency_trim;
  localparam int TO = 8;
  localparam logic [7:0] A_RANK = 8'h10, A_GTR = 8'h20, A_GCR = 8'h30,
                         A_TMG = 8'h40, A_SWC = 8'h41, A_SWS = 8'h42;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, err, bus_req, bus_we, bus_ack;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #2 clk = ~clk;

  gate_latency_trim #(.ACK_TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  // register model
  logic [31:0] mem [256];
  logic [31:0] gtr_i [4];
  logic [31:0] gcr_i [4];
  logic [31:0] tmg_i, swc_i;
  int          sws_k;
  logic        load = 0;
  int          polls;
  logic        l_we;
  logic [7:0]  l_addr;
  logic [31:0] l_wdata;

  always @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < 4; i++) begin
        mem[A_GTR + i] <= gtr_i[i];
        mem[A_GCR + i] <= gcr_i[i];
      end
      mem[A_TMG] <= tmg_i; mem[A_SWC] <= swc_i; mem[A_RANK] <= 32'hDEAD;
      polls <= 0; bus_ack <= 1'b0;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1; l_we <= bus_we; l_addr <= bus_addr; l_wdata <= bus_wdata;
      if (bus_we) mem[bus_addr] <= bus_wdata;
      if (!bus_we && bus_addr == A_SWS) begin
        bus_rdata <= {31'd0, polls >= sws_k};
        polls <= polls + 1;
      end else bus_rdata <= mem[bus_addr];
    end else bus_ack <= 1'b0;
  end

  typedef struct {logic we; logic [7:0] addr; logic [31:0] data; string tag;} item_t;
  item_t exp_q[$];
  int checks = 0, fails = 0, stab_err = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic push(input logic we, input logic [7:0] a, input logic [31:0] d, input string tag);
    item_t it;
    it.we = we; it.addr = a; it.data = d; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic monitor();
    logic       p_req = 0, p_ack = 0, p_we = 0;
    logic [7:0] p_addr = 0;
    forever begin
      @(negedge clk);
      if (p_req && !p_ack && (!bus_req || bus_we != p_we || bus_addr != p_addr)) stab_err++;
      p_req = bus_req; p_ack = bus_ack; p_we = bus_we; p_addr = bus_addr;
      if (bus_ack) begin
        if (exp_q.size() == 0) check(0, "R9 unexpected transaction", {24'd0, l_addr}, 32'hFFFF_FFFF);
        else begin
          item_t e;
          e = exp_q.pop_front();
          check(l_we == e.we && l_addr == e.addr, {e.tag, " kind/address"},
                {23'd0, l_we, l_addr}, {23'd0, e.we, e.addr});
          if (e.we) check(l_wdata == e.data, {e.tag, " write data"}, l_wdata, e.data);
        end
      end
    end
  endtask

  task automatic run(input int k, input bit poke);
    int mn = 7, mx = 0, rd, inc, n;
    logic [31:0] gv, swc_c, t1, t2;
    string tg;
    @(negedge clk); load = 1; @(negedge clk); load = 0; sws_k = k;
    push(1, A_RANK, 0, "R2 rank select");
    for (int i = 0; i < 4; i++) begin
      int l;
      l = int'(gtr_i[i] & 32'h1F);
      if ((l >> 2) < mn) mn = l >> 2;
      if (l > mx) mx = l;
      push(0, A_GTR + 8'(i), 0, "R3 lane read");
    end
    rd = mn + 5; if (rd > 15) rd = 15;
    inc = mx >> 1;
    for (int i = 0; i < 4; i++) begin
      gv = (gcr_i[i] & ~32'h00F0_0000) | (32'(rd) << 20);
      push(0, A_GCR + 8'(i), 0, "R4 cfg read");
      push(1, A_GCR + 8'(i), gv, "R4 cfg write");
    end
    swc_c = swc_i & ~32'd1;
    t1 = tmg_i + (32'(inc) << 8);
    t2 = t1 + 32'(inc);
    push(0, A_SWC, 0, "R6 swctl read"); push(1, A_SWC, swc_c, "R6 swctl clear");
    push(0, A_TMG, 0, "R5 tmg read");   push(1, A_TMG, t1, "R5 rd2wr add");
    push(0, A_TMG, 0, "R5 tmg read");   push(1, A_TMG, t2, "R5 wr2rd add");
    push(0, A_SWC, 0, "R6 swctl read"); push(1, A_SWC, swc_c | 1, "R6 swctl set");
    n = (k < TO) ? k + 1 : TO;
    tg = (k < TO) ? "R7 status poll" : "R8 status poll";
    for (int i = 0; i < n; i++) push(0, A_SWS, 0, tg);
    start = 1; @(negedge clk); start = 0;
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    while (!done) @(negedge clk);
    check(err == (k >= TO), (k < TO) ? "R7 err flag" : "R8 err flag", {31'd0, err}, {31'd0, k >= TO});
    repeat (20) begin
      @(negedge clk);
      if (done || bus_req) check(0, "R9 activity after done", {30'd0, done, bus_req}, 0);
    end
    check(busy == 0, "R9 idle after run", {31'd0, busy}, 0);
    check(exp_q.size() == 0, "R3 all transactions seen", exp_q.size(), 0);
    for (int i = 0; i < 4; i++)
      check(mem[A_GCR + i] == ((gcr_i[i] & ~32'h00F0_0000) | (32'(rd) << 20)), "R4 final cfg",
            mem[A_GCR + i], (gcr_i[i] & ~32'h00F0_0000) | (32'(rd) << 20));
    check(mem[A_TMG] == t2, "R5 final timing", mem[A_TMG], t2);
    check(mem[A_SWC] == (swc_c | 1), "R6 final swctl", mem[A_SWC], swc_c | 1);
    check(stab_err == 0, "R10 request held until ack", stab_err, 0);
    exp_q.delete();
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bus_ack = 0; bus_rdata = 0; sws_k = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !bus_req, "R1 reset state",
          {28'd0, busy, done, err, bus_req}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!bus_req, "R1 idle quiet", {31'd0, bus_req}, 0);
    fork monitor(); join_none
    // mixed lanes with high garbage bits
    gtr_i = '{32'hFFFF_FF13, 32'h0000_000C, 32'h1234_561F, 32'h8000_0008};
    gcr_i = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_A5A5, 32'h0F0F_0F0F};
    tmg_i = 32'h0102_0304; swc_i = 32'h0000_00F1;
    run(2, 0);
    // all zero latency
    gtr_i = '{32'hFFFF_FFE0, 32'h0, 32'h0, 32'h0};
    gcr_i = '{32'h00F0_0000, 32'h1, 32'h2, 32'h3};
    tmg_i = 32'h0000_0707; swc_i = 32'h0;
    run(0, 0);
    // all max latency, timing register near wrap
    gtr_i = '{32'h1F, 32'h1F, 32'h1F, 32'h1F};
    gcr_i = '{32'h0, 32'hFF0F_FFFF, 32'h0, 32'hFFFF_FFFF};
    tmg_i = 32'hFFFF_FFF8; swc_i = 32'hFFFF_FFFF;
    run(3, 0);
    // acknowledge never arrives
    gtr_i = '{32'h04, 32'h09, 32'h10, 32'h03};
    gcr_i = '{32'h1, 32'h2, 32'h3, 32'h4};
    tmg_i = 32'h0000_1000; swc_i = 32'h2;
    run(100, 0);
    // recovery after timeout, stray start mid-run
    gtr_i = '{32'h11, 32'h0E, 32'h17, 32'h15};
    gcr_i = '{32'h1234_5678, 32'h8765_4321, 32'h0, 32'hFFFF_FFFF};
    tmg_i = 32'h0000_0000; swc_i = 32'h1;
    run(1, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule